// File: doc/BRIEF.md
# Sliding-Window Bit Correlation Updater

This block maintains two running correlation products over a sliding window of the most recent L bit periods. The first is the K×K auto-correlation of hard user decisions. The second is the K×N cross-correlation between those decisions and the received samples, kept as separate real and imaginary matrices. A downstream channel estimator reads both matrices. Each bit period a strobe delivers K one-bit decisions and N signed samples on each of the real and imaginary rails. The block adds the contribution of the newest vector. Once the window is full, it also removes the contribution of the vector that drops out of the window.

The block has no multipliers. A product of two bits is an XNOR feeding a saturating up/down step. A product of a bit and a sample is the sample added or subtracted, as the bit's sign selects. One element is updated per clock in a serial sweep, and a done pulse marks the end of the sweep. A registered row/column read port gives access to every element at any time.

Top module: `bl_corr_top`

## Requirements
- R1: After reset every auto- and cross-correlation element reads 0, and `busy`, `done`, `ovf` and `fill` are all 0.
- R2: A decision bit of 1 stands for +1 and a bit of 0 stands for −1. For each new vector, auto element (i,j) gains +1 when bits i and j are equal and −1 when they differ.
- R3: When a vector is accepted with `fill` already equal to L, each element also loses the contribution of the vector accepted L strobes earlier. The new and old terms are applied together in one step.
- R4: Cross element (i,n) on each rail gains +sample n of that rail when bit i is 1 and −sample n when bit i is 0. Samples are two's-complement, and sample n occupies bits [8n+7:8n] of its rail.
- R5: Every element saturates at +127 and −128 instead of wrapping. The `ovf` output goes high on the first clipped update and stays high until reset.
- R6: A strobe seen while idle starts a sweep. `busy` stays high for exactly K·K+K·N cycles, and `done` is high for one cycle on the cycle after the last update, with `busy` low at that time.
- R7: A `bit_valid` strobe that arrives while `busy` is high has no effect on any element or on `fill`.
- R8: `rd_sel` 0 selects auto element (`rd_row`, `rd_col`), 1 selects real cross element (`rd_row`, `rd_col`), and 2 selects imaginary cross element (`rd_row`, `rd_col`). The value appears on `rd_data` one clock after the address.
- R9: `fill` counts accepted vectors and stops at L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | New bit period strobe; starts a sweep when idle |
| bits_in | input | K | User decisions, 1 = +1, 0 = −1 |
| re_in | input | N·8 | Real samples, sample n at bits [8n+7:8n] |
| im_in | input | N·8 | Imaginary samples, same packing |
| rd_sel | input | 2 | Matrix select: 0 auto, 1 real cross, 2 imaginary cross |
| rd_row | input | clog2(K) | Read row (user index) |
| rd_col | input | clog2(max(K,N)) | Read column (user or sample index) |
| rd_data | output | 8 | Registered element value, signed |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at sweep end |
| fill | output | clog2(L+1) | Window occupancy |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The hardest state to reach is a cross element that has been pinned at a rail and then has a window-exit term subtracted. From there the element must move away from the clipped value, not from the true running sum. The bench reaches this state with a directed run of identical full-scale vectors that overfills the window, then flips the decision bits, and compares against a model that saturates step by step. Strobes dropped into the middle of a sweep check that the latched vector is not disturbed.

// File: rtl/bl_corr_pkg.sv
package bl_corr_pkg;
  typedef enum logic [1:0] {
    SEL_AUTO = 2'd0,
    SEL_XRE  = 2'd1,
    SEL_XIM  = 2'd2
  } rd_sel_e;

  typedef enum logic {
    PH_AUTO  = 1'b0,
    PH_CROSS = 1'b1
  } phase_e;
endpackage

// File: rtl/bl_window_buf.sv
module bl_window_buf #(
  parameter int DW = 8,
  parameter int L  = 8,
  parameter int FW = $clog2(L + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] new_q,
  output logic [DW-1:0] old_q,
  output logic          old_v,
  output logic [FW-1:0] fill
);
  localparam int PW = (L > 1) ? $clog2(L) : 1;

  logic [DW-1:0] mem [L];
  logic [PW-1:0] ptr;

  // Read-before-write on the slot that is about to be reused.
  always_ff @(posedge clk) begin
    if (accept) begin
      old_q    <= mem[ptr];
      mem[ptr] <= din;
      new_q    <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      fill  <= '0;
      old_v <= 1'b0;
    end else if (accept) begin
      ptr   <= (ptr == PW'(L - 1)) ? '0 : ptr + 1'b1;
      old_v <= (fill == FW'(L));
      if (fill != FW'(L)) fill <= fill + 1'b1;
    end
  end

  a_r9_fill_limit: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(L));
  a_r3_old_only_full: assert property (@(posedge clk) disable iff (rst)
    accept && (fill != FW'(L)) |=> !old_v);
endmodule

// File: rtl/bl_sweep_ctrl.sv
module bl_sweep_ctrl
  import bl_corr_pkg::*;
#(
  parameter int K  = 4,
  parameter int N  = 8,
  parameter int RW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output phase_e        phase,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  logic [CW-1:0] col_last;
  assign col_last = (phase == PH_AUTO) ? CW'(K - 1) : CW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= PH_AUTO;
      row   <= '0;
      col   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= PH_AUTO;
          row   <= '0;
          col   <= '0;
        end
      end else if (col == col_last) begin
        col <= '0;
        if (row == RW'(K - 1)) begin
          row <= '0;
          if (phase == PH_AUTO) begin
            phase <= PH_CROSS;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/bl_sat_step.sv
module bl_sat_step #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] cur,
  input  logic signed [W+1:0] add_t,
  input  logic signed [W+1:0] sub_t,
  output logic signed [W-1:0] nxt,
  output logic                clip
);
  localparam int SW = W + 3;
  localparam logic signed [SW-1:0] HI = SW'((2 ** (W - 1)) - 1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [SW-1:0] sum;

  always_comb begin
    sum = {{3{cur[W-1]}}, cur} + {add_t[W+1], add_t} - {sub_t[W+1], sub_t};
    clip = 1'b0;
    if (sum > HI) begin
      nxt  = HI[W-1:0];
      clip = 1'b1;
    end else if (sum < LO) begin
      nxt  = LO[W-1:0];
      clip = 1'b1;
    end else begin
      nxt = sum[W-1:0];
    end
  end
endmodule

// File: rtl/bl_corr_top.sv
module bl_corr_top
  import bl_corr_pkg::*;
#(
  parameter int K  = 4,
  parameter int N  = 8,
  parameter int L  = 8,
  parameter int W  = 8,
  parameter int RW = (K > 1) ? $clog2(K) : 1,
  parameter int CW = ((K > N ? K : N) > 1) ? $clog2(K > N ? K : N) : 1,
  parameter int FW = $clog2(L + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  input  logic [K-1:0]  bits_in,
  input  logic [N*W-1:0] re_in,
  input  logic [N*W-1:0] im_in,
  input  logic [1:0]    rd_sel,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] fill,
  output logic          ovf
);
  localparam int DW = K + 2 * N * W;
  localparam logic signed [W+1:0] P1 = (W + 2)'(1);

  logic accept;
  logic [DW-1:0] new_w, old_w;
  logic old_v;
  phase_e phase;
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  assign accept = bit_valid && !busy;

  bl_window_buf #(.DW(DW), .L(L), .FW(FW)) win_i (
    .clk(clk), .rst(rst), .accept(accept),
    .din({bits_in, re_in, im_in}),
    .new_q(new_w), .old_q(old_w), .old_v(old_v), .fill(fill)
  );

  bl_sweep_ctrl #(.K(K), .N(N), .RW(RW), .CW(CW)) ctl_i (
    .clk(clk), .rst(rst), .start(bit_valid),
    .busy(busy), .done(done), .phase(phase), .row(row), .col(col)
  );

  logic [K-1:0]   nb, ob;
  logic [N*W-1:0] nre, nim, ore, oim;
  assign {nb, nre, nim} = new_w;
  assign {ob, ore, oim} = old_w;

  logic signed [W-1:0] rbb [K][K];
  logic signed [W-1:0] rre [K][N];
  logic signed [W-1:0] rim [K][N];

  // Auto term: XNOR of two decisions selects +1 or -1.
  logic p_new, p_old;
  logic signed [W+1:0] bb_add, bb_sub;
  logic signed [W-1:0] bb_nxt;
  logic bb_clip;
  assign p_new  = ~(nb[row] ^ nb[col]);
  assign p_old  = ~(ob[row] ^ ob[col]);
  assign bb_add = p_new ? P1 : -P1;
  assign bb_sub = !old_v ? '0 : (p_old ? P1 : -P1);

  bl_sat_step #(.W(W)) bb_step_i (
    .cur(rbb[row][col]), .add_t(bb_add), .sub_t(bb_sub),
    .nxt(bb_nxt), .clip(bb_clip)
  );

  // Cross terms: decision sign picks add or subtract of the sample.
  logic signed [W+1:0] sre_n, sre_o, sim_n, sim_o;
  logic signed [W+1:0] re_add, re_sub, im_add, im_sub;
  logic signed [W-1:0] re_nxt, im_nxt;
  logic re_clip, im_clip;
  logic [W-1:0] t_nre, t_ore, t_nim, t_oim;

  always_comb begin
    t_nre = nre[col*W +: W];
    t_ore = ore[col*W +: W];
    t_nim = nim[col*W +: W];
    t_oim = oim[col*W +: W];
    sre_n = {{2{t_nre[W-1]}}, t_nre};
    sre_o = {{2{t_ore[W-1]}}, t_ore};
    sim_n = {{2{t_nim[W-1]}}, t_nim};
    sim_o = {{2{t_oim[W-1]}}, t_oim};
    re_add = nb[row] ? sre_n : -sre_n;
    im_add = nb[row] ? sim_n : -sim_n;
    re_sub = !old_v ? '0 : (ob[row] ? sre_o : -sre_o);
    im_sub = !old_v ? '0 : (ob[row] ? sim_o : -sim_o);
  end

  bl_sat_step #(.W(W)) re_step_i (
    .cur(rre[row][col]), .add_t(re_add), .sub_t(re_sub),
    .nxt(re_nxt), .clip(re_clip)
  );
  bl_sat_step #(.W(W)) im_step_i (
    .cur(rim[row][col]), .add_t(im_add), .sub_t(im_sub),
    .nxt(im_nxt), .clip(im_clip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K; i++) begin
        for (int j = 0; j < K; j++) rbb[i][j] <= '0;
        for (int n = 0; n < N; n++) begin
          rre[i][n] <= '0;
          rim[i][n] <= '0;
        end
      end
      ovf <= 1'b0;
    end else if (busy) begin
      if (phase == PH_AUTO) begin
        rbb[row][col] <= bb_nxt;
        if (bb_clip) ovf <= 1'b1;
      end else begin
        rre[row][col] <= re_nxt;
        rim[row][col] <= im_nxt;
        if (re_clip || im_clip) ovf <= 1'b1;
      end
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_sel)
        SEL_AUTO: if (int'(rd_row) < K && int'(rd_col) < K) rd_data <= rbb[rd_row][rd_col];
        SEL_XRE:  if (int'(rd_row) < K && int'(rd_col) < N) rd_data <= rre[rd_row][rd_col];
        SEL_XIM:  if (int'(rd_row) < K && int'(rd_col) < N) rd_data <= rim[rd_row][rd_col];
        default:  rd_data <= '0;
      endcase
    end
  end

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r7_fill_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(fill));
  a_r5_clip_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    busy && (phase == PH_CROSS) && re_clip |=> ovf);
endmodule

// File: tb/bl_corr_top_tb_top.sv
`timescale 1ns/1ps
module bl_corr_top_tb_top;
  localparam int K = 4, N = 8, L = 8, W = 8;
  localparam int RW = 2, CW = 3, FW = 4;
  localparam int T = K * K + K * N;
  localparam int MAXV = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic [K-1:0] bits_in = '0;
  logic [N*W-1:0] re_in = '0, im_in = '0;
  logic [1:0] rd_sel = '0;
  logic [RW-1:0] rd_row = '0;
  logic [CW-1:0] rd_col = '0;
  logic [W-1:0] rd_data;
  logic busy, done, ovf;
  logic [FW-1:0] fill;

  always #4 clk = ~clk;

  bl_corr_top #(.K(K), .N(N), .L(L), .W(W)) dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bits_in(bits_in),
    .re_in(re_in), .im_in(im_in), .rd_sel(rd_sel), .rd_row(rd_row),
    .rd_col(rd_col), .rd_data(rd_data), .busy(busy), .done(done),
    .fill(fill), .ovf(ovf)
  );

  int n_chk = 0, n_fail = 0;

  // Bench model state
  logic [K-1:0]   vb  [MAXV];
  logic [N*W-1:0] vre [MAXV];
  logic [N*W-1:0] vim [MAXV];
  int cnt;
  int ebb [K][K];
  int ere [K][N];
  int eim [K][N];
  bit eovf;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, inout bit f);
    if (v > 127) begin f = 1'b1; return 127; end
    if (v < -128) begin f = 1'b1; return -128; end
    return v;
  endfunction

  function automatic int sgn(input logic b);
    return b ? 1 : -1;
  endfunction

  function automatic int smp(input logic [N*W-1:0] v, input int n);
    return int'($signed(v[n*W +: W]));
  endfunction

  task automatic model_reset();
    cnt = 0;
    eovf = 1'b0;
    for (int i = 0; i < K; i++) begin
      for (int j = 0; j < K; j++) ebb[i][j] = 0;
      for (int n = 0; n < N; n++) begin ere[i][n] = 0; eim[i][n] = 0; end
    end
  endtask

  task automatic model_push(input logic [K-1:0] b, input logic [N*W-1:0] re, input logic [N*W-1:0] im);
    bit full;
    int o;
    full = (cnt >= L);
    o = cnt - L;
    vb[cnt] = b; vre[cnt] = re; vim[cnt] = im;
    for (int i = 0; i < K; i++) begin
      for (int j = 0; j < K; j++)
        ebb[i][j] = sat(ebb[i][j] + sgn(b[i]) * sgn(b[j])
                        - (full ? sgn(vb[o][i]) * sgn(vb[o][j]) : 0), eovf);
      for (int n = 0; n < N; n++) begin
        ere[i][n] = sat(ere[i][n] + sgn(b[i]) * smp(re, n)
                        - (full ? sgn(vb[o][i]) * smp(vre[o], n) : 0), eovf);
        eim[i][n] = sat(eim[i][n] + sgn(b[i]) * smp(im, n)
                        - (full ? sgn(vb[o][i]) * smp(vim[o], n) : 0), eovf);
      end
    end
    cnt++;
  endtask

  task automatic rd(input int sel, input int r, input int c, output int v);
    @(negedge clk);
    rd_sel = 2'(sel); rd_row = RW'(r); rd_col = CW'(c);
    @(negedge clk);
    v = int'($signed(rd_data));
  endtask

  task automatic check_all(input string req);
    int v;
    for (int i = 0; i < K; i++) begin
      for (int j = 0; j < K; j++) begin rd(0, i, j, v); chk({req, " auto"}, v, ebb[i][j]); end
      for (int n = 0; n < N; n++) begin
        rd(1, i, n, v); chk({req, " xre"}, v, ere[i][n]);
        rd(2, i, n, v); chk({req, " xim"}, v, eim[i][n]);
      end
    end
    chk("R5 ovf", int'(ovf), int'(eovf));
    chk("R9 fill", int'(fill), (cnt < L) ? cnt : L);
  endtask

  // Send one vector; optional strobe with other data in mid-sweep (R7).
  task automatic send(input logic [K-1:0] b, input logic [N*W-1:0] re, input logic [N*W-1:0] im, input bit glitch);
    int cyc;
    @(negedge clk);
    bits_in = b; re_in = re; im_in = im; bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R6 busy", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < T + 5) begin
      @(negedge clk);
      cyc++;
      if (glitch && cyc == 3) begin
        bits_in = ~b; re_in = ~re; im_in = ~im; bit_valid = 1'b1;
      end
      if (glitch && cyc == 4) bit_valid = 1'b0;
    end
    chk("R6 sweep length", cyc, T);
    chk("R6 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    model_push(b, re, im);
  endtask

  function automatic logic [N*W-1:0] rand_samples(input bit extreme);
    logic [N*W-1:0] v;
    for (int n = 0; n < N; n++) begin
      if (extreme) v[n*W +: W] = ($urandom % 2) ? 8'h7F : 8'h80;
      else v[n*W +: W] = W'($urandom);
    end
    return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    logic [N*W-1:0] ramp;
    seed = $urandom(32'd1234);
    do_reset();
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 fill", int'(fill), 0);
    check_all("R1");

    // R2/R4/R8: single directed vector with mixed bits and ramp samples
    for (int n = 0; n < N; n++) ramp[n*W +: W] = W'(n * 13 - 50);
    send(4'b1010, ramp, ~ramp, 1'b0);
    check_all("R2 R4 R8");

    // R7: strobe with other data while busy
    send(4'b0110, rand_samples(0), rand_samples(0), 1'b1);
    check_all("R7");

    // Random fill past the window; R3 once the window is full
    for (int k = 0; k < 24; k++) begin
      send(K'($urandom), rand_samples(k % 5 == 0), rand_samples(0), (k % 7) == 3);
      check_all((cnt > L) ? "R3" : "R4");
    end

    // R5: saturate and then exit saturated terms from the window
    do_reset();
    for (int n = 0; n < N; n++) begin ramp[n*W +: W] = 8'h7F; end
    send('1, ramp, {N{8'h80}}, 1'b0);
    check_all("R5 edge no clip");
    for (int k = 0; k < L + 2; k++) begin
      send('1, ramp, {N{8'h80}}, 1'b0);
      check_all("R5 pinned");
    end
    send('0, ramp, {N{8'h80}}, 1'b0);
    check_all("R5 leave rail R3");
    for (int k = 0; k < 6; k++) begin
      send(K'($urandom), rand_samples(1), rand_samples(1), 1'b0);
      check_all("R5 R3 random extreme");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule